// File: doc/BRIEF.md
# Memory Operation Pool for an Out-of-Order Floating-Point Core

This block holds the memory operations of a dynamically scheduled floating-point core while they wait on memory or on their data. It behaves like any other functional unit of the core. Each load slot owns a result tag. When the memory word returns, the slot offers it on the shared result bus under that tag. Waiting arithmetic stations pick the value up there, so they never read a register for it.

A store slot keeps its address and either the data to write or the tag of the station that will produce that data. While it holds only a tag, the slot watches the result bus and takes the value in the cycle its producer's tag appears. A store goes to memory only once it has its data, and it frees its slot when memory accepts the write.

The core's issue stage writes into the pool. The pool drives a single memory request port with in-order load responses. An external arbiter grants the result bus, and the bus that arbiter grants is fed back as a snoop input. The pool does not compare load addresses with store addresses.

Top module: `memop_pool`

## Requirements
- R1: After reset all slots are free: `iss_ld_ready` and `iss_st_ready` are 1, `iss_ld_tag` is 1, and `mem_req_valid` and `res_req` are 0.
- R2: There are six load slots. A load is taken when `iss_ld_valid` and `iss_ld_ready` are both high, and it goes into the lowest-numbered free slot. Slot k carries tag k+1, so load tags are 1 to 6, and `iss_ld_tag` shows the tag the next load will get. With all six slots busy, `iss_ld_ready` is 0 and an offered load is dropped.
- R3: There are three store slots, filled lowest-numbered first. With all three busy, `iss_st_ready` is 0.
- R4: Load reads go to memory as requests with `mem_req_we`=0, oldest load first. While `mem_req_ready` is low, the request and its address stay steady. Memory returns one response per accepted read, in the order the reads were accepted.
- R5: A load response is captured at the edge where `mem_rsp_valid` is high. From the next cycle on, `res_req` is 1 with that load's tag and data. With memory that accepts at once and answers one cycle later, a load issued at edge n has its data at edge n+2 and requests the bus in the cycle after that edge.
- R6: Only one load is offered on the bus at a time. When several loads hold data, the lowest tag goes first. The offer stays up until `res_grant` is high, and that slot frees at the same edge.
- R7: A store asks memory to write (`mem_req_we`=1) only once its data is known. It shows its address and data, and it frees its slot at the edge where `mem_req_ready` is high.
- R8: A store issued with `iss_st_src`=0 has its data ready. Otherwise it waits for that tag on the snoop bus (`snp_valid`, `snp_tag`, `snp_data`). It takes the data at the edge where the tag matches, and that includes the issue cycle itself. Every waiting store with that tag takes the data. Snoops carrying other tags change nothing.
- R9: A pending load read always wins the memory port over a store. Among stores that are ready to write, the lowest-numbered slot goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_ld_valid | input | 1 | Load issue request |
| iss_ld_addr | input | AW | Effective address of the load |
| iss_ld_ready | output | 1 | A load slot is free |
| iss_ld_tag | output | TW | Tag the next load will receive |
| iss_st_valid | input | 1 | Store issue request |
| iss_st_addr | input | AW | Effective address of the store |
| iss_st_data | input | DW | Store data when `iss_st_src` is 0 |
| iss_st_src | input | TW | Producer tag of the store data, 0 if the data is ready |
| iss_st_ready | output | 1 | A store slot is free |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_req_ready | input | 1 | Memory accepts the request at this edge |
| mem_rsp_valid | input | 1 | Read data returned, oldest read first |
| mem_rsp_data | input | DW | Read data |
| res_req | output | 1 | A load asks for the result bus |
| res_tag | output | TW | Tag of the offered result |
| res_data | output | DW | Offered result |
| res_grant | input | 1 | Bus granted to this pool at this edge |
| snp_valid | input | 1 | Result bus carries a value |
| snp_tag | input | TW | Tag on the result bus |
| snp_data | input | DW | Value on the result bus |

## Verification
Each result has its own delay from the stimulus that causes it. A load issued at one edge shows its read request in the next cycle. With a memory that answers one cycle after accepting, the load's bus request appears two edges later. A slot frees at the grant edge. A snooped value is taken at the matching edge, and the store's write request follows in the next cycle. The bench drives every input on the falling clock edge and samples outputs on later falling edges, after exactly the rising edges these delays call for. A memory model that answers one cycle after accepting produces the read data and keeps a log of the writes, so ignored snoops and dropped issues can be checked at the ports.

// File: rtl/memop_pool.sv
module memop_pool #(
  parameter int LD_N = 6,
  parameter int ST_N = 3,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 4,
  parameter int LD_TAG_BASE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_ld_valid,
  input  logic [AW-1:0] iss_ld_addr,
  output logic          iss_ld_ready,
  output logic [TW-1:0] iss_ld_tag,
  input  logic          iss_st_valid,
  input  logic [AW-1:0] iss_st_addr,
  input  logic [DW-1:0] iss_st_data,
  input  logic [TW-1:0] iss_st_src,
  output logic          iss_st_ready,
  output logic          mem_req_valid,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          res_req,
  output logic [TW-1:0] res_tag,
  output logic [DW-1:0] res_data,
  input  logic          res_grant,
  input  logic          snp_valid,
  input  logic [TW-1:0] snp_tag,
  input  logic [DW-1:0] snp_data
);
  localparam int LI = (LD_N > 1) ? $clog2(LD_N) : 1;
  localparam int SI = (ST_N > 1) ? $clog2(ST_N) : 1;
  localparam int CW = $clog2(LD_N + 1);

  logic [LD_N-1:0] ld_busy, ld_done;
  logic [AW-1:0]   ld_addr [LD_N];
  logic [DW-1:0]   ld_data [LD_N];
  logic [LI-1:0]   q [LD_N];
  logic [LI-1:0]   q_hd, q_rq, q_tl;
  logic [CW-1:0]   n_unsent;

  logic [ST_N-1:0] st_busy, st_wait, snp_hit;
  logic [AW-1:0]   st_addr [ST_N];
  logic [DW-1:0]   st_data [ST_N];
  logic [TW-1:0]   st_src  [ST_N];

  logic [LI-1:0] ld_free, bc_idx;
  logic [SI-1:0] st_free, st_sel;
  logic          ld_any, st_any, st_rdy_any;
  logic          ld_take, st_take, ld_pend, ld_acc, st_acc, bc_fire;

  function automatic logic [LI-1:0] nxt(input logic [LI-1:0] p);
    return (p == LI'(LD_N - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    ld_free = '0; ld_any = 1'b0; bc_idx = '0;
    for (int i = LD_N - 1; i >= 0; i--) begin
      if (!ld_busy[i]) begin ld_free = LI'(i); ld_any = 1'b1; end
      if (ld_done[i]) bc_idx = LI'(i);
    end
    st_free = '0; st_any = 1'b0; st_sel = '0; st_rdy_any = 1'b0;
    for (int j = ST_N - 1; j >= 0; j--) begin
      snp_hit[j] = snp_valid && (snp_tag == st_src[j]);
      if (!st_busy[j]) begin st_free = SI'(j); st_any = 1'b1; end
      if (st_busy[j] && !st_wait[j]) begin st_sel = SI'(j); st_rdy_any = 1'b1; end
    end
  end

  assign iss_ld_ready  = ld_any;
  assign iss_ld_tag    = TW'(LD_TAG_BASE) + TW'(ld_free);
  assign iss_st_ready  = st_any;
  assign ld_take       = iss_ld_valid && ld_any;
  assign st_take       = iss_st_valid && st_any;

  assign ld_pend       = (n_unsent != '0);
  assign mem_req_valid = ld_pend || st_rdy_any;
  assign mem_req_we    = !ld_pend;
  assign mem_req_addr  = ld_pend ? ld_addr[q[q_rq]] : st_addr[st_sel];
  assign mem_req_wdata = st_data[st_sel];
  assign ld_acc        = ld_pend && mem_req_ready;
  assign st_acc        = !ld_pend && st_rdy_any && mem_req_ready;

  assign res_req  = |ld_done;
  assign res_tag  = TW'(LD_TAG_BASE) + TW'(bc_idx);
  assign res_data = ld_data[bc_idx];
  assign bc_fire  = res_req && res_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_busy <= '0; ld_done <= '0;
      q_hd <= '0; q_rq <= '0; q_tl <= '0; n_unsent <= '0;
    end else begin
      if (ld_take) begin
        ld_busy[ld_free] <= 1'b1;
        q_tl <= nxt(q_tl);
      end
      if (bc_fire) begin
        ld_busy[bc_idx] <= 1'b0;
        ld_done[bc_idx] <= 1'b0;
      end
      if (mem_rsp_valid) begin
        ld_done[q[q_hd]] <= 1'b1;
        q_hd <= nxt(q_hd);
      end
      if (ld_acc) q_rq <= nxt(q_rq);
      n_unsent <= n_unsent + CW'(ld_take) - CW'(ld_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (ld_take) begin
      ld_addr[ld_free] <= iss_ld_addr;
      q[q_tl] <= ld_free;
    end
    if (mem_rsp_valid) ld_data[q[q_hd]] <= mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_busy <= '0; st_wait <= '0;
    end else begin
      for (int j = 0; j < ST_N; j++)
        if (st_busy[j] && st_wait[j] && snp_hit[j]) st_wait[j] <= 1'b0;
      if (st_take) begin
        st_busy[st_free] <= 1'b1;
        st_wait[st_free] <= (iss_st_src != '0) && !(snp_valid && snp_tag == iss_st_src);
      end
      if (st_acc) st_busy[st_sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < ST_N; j++)
      if (st_busy[j] && st_wait[j] && snp_hit[j]) st_data[j] <= snp_data;
    if (st_take) begin
      st_addr[st_free] <= iss_st_addr;
      st_src[st_free]  <= iss_st_src;
      st_data[st_free] <= (iss_st_src == '0) ? iss_st_data : snp_data;
    end
  end

  assert_ld_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_take |=> ld_busy != $past(ld_busy));

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we && !mem_req_ready |=>
      mem_req_valid && !mem_req_we && $stable(mem_req_addr));

  assert_rsp_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> res_req);

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_req && !res_grant && !mem_rsp_valid |=>
      res_req && $stable(res_tag) && $stable(res_data));

  assert_st_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && mem_req_ready |=>
      $countones(st_busy) <= $past($countones(st_busy)));
endmodule

// File: tb/memop_pool_bench.sv
`timescale 1ns/1ps
module memop_pool_bench;
  localparam int AW = 16, DW = 32, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_ld_valid = 0; logic [AW-1:0] iss_ld_addr = '0;
  logic iss_ld_ready; logic [TW-1:0] iss_ld_tag;
  logic iss_st_valid = 0; logic [AW-1:0] iss_st_addr = '0;
  logic [DW-1:0] iss_st_data = '0; logic [TW-1:0] iss_st_src = '0;
  logic iss_st_ready;
  logic mem_req_valid, mem_req_we; logic [AW-1:0] mem_req_addr; logic [DW-1:0] mem_req_wdata;
  logic mem_req_ready = 0;
  logic mem_rsp_valid; logic [DW-1:0] mem_rsp_data;
  logic res_req; logic [TW-1:0] res_tag; logic [DW-1:0] res_data;
  logic res_grant = 0;
  logic snp_valid = 0; logic [TW-1:0] snp_tag = '0; logic [DW-1:0] snp_data = '0;

  int checks = 0, failures = 0, wr_count = 0;
  logic [AW-1:0] wr_addr [8];
  logic [DW-1:0] wr_data [8];
  bit done = 0;

  always #2 clk = ~clk;

  memop_pool u_memop_pool (.*);

  function automatic logic [DW-1:0] mdat(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_we;
      mem_rsp_data  <= mdat(mem_req_addr);
      if (mem_req_valid && mem_req_ready && mem_req_we && wr_count < 8) begin
        wr_addr[wr_count] <= mem_req_addr;
        wr_data[wr_count] <= mem_req_wdata;
        wr_count <= wr_count + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drain();
    res_grant = 1; mem_req_ready = 1;
    repeat (12) @(negedge clk);
    res_grant = 0;
    chk("R2 idle ready", iss_ld_ready, 1);
    chk("R3 idle ready", iss_st_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ld_ready", iss_ld_ready, 1);
    chk("R1 st_ready", iss_st_ready, 1);
    chk("R1 tag", iss_ld_tag, 1);
    chk("R1 mem_req", mem_req_valid, 0);
    chk("R1 res_req", res_req, 0);
  endtask

  task automatic t_single_load();
    mem_req_ready = 1; res_grant = 0;
    iss_ld_valid = 1; iss_ld_addr = 16'h0040;
    chk("R2 first tag", iss_ld_tag, 1);
    @(negedge clk); iss_ld_valid = 0;
    chk("R4 rd valid", mem_req_valid, 1);
    chk("R4 rd we", mem_req_we, 0);
    chk("R4 rd addr", mem_req_addr, 16'h0040);
    @(negedge clk);
    chk("R5 not yet", res_req, 0);
    @(negedge clk);
    chk("R5 offer", res_req, 1);
    chk("R5 tag", res_tag, 1);
    chk("R5 data", res_data, mdat(16'h0040));
    @(negedge clk);
    chk("R6 held", res_req, 1);
    res_grant = 1;
    @(negedge clk); res_grant = 0;
    chk("R6 freed", res_req, 0);
    chk("R2 slot back", iss_ld_tag, 1);
  endtask

  task automatic t_fill_loads();
    int got;
    mem_req_ready = 0; res_grant = 0;
    for (int i = 0; i < 6; i++) begin
      iss_ld_valid = 1; iss_ld_addr = 16'h0100 + 16'(4 * i);
      chk("R2 tag order", iss_ld_tag, i + 1);
      @(negedge clk);
    end
    chk("R2 full", iss_ld_ready, 0);
    iss_ld_addr = 16'h0F00;
    @(negedge clk); iss_ld_valid = 0;
    chk("R4 oldest held", mem_req_addr, 16'h0100);
    mem_req_ready = 1;
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      chk("R4 age order", mem_req_addr, 16'h0100 + 16'(4 * i));
    end
    @(negedge clk);
    chk("R2 dropped load", mem_req_valid, 0);
    res_grant = 1; got = 0;
    for (int c = 0; c < 12; c++) begin
      if (res_req && got < 6) begin
        chk("R6 tag seq", res_tag, got + 1);
        chk("R5 data seq", res_data, mdat(16'h0100 + 16'(4 * got)));
        got++;
      end
      @(negedge clk);
    end
    chk("R6 six broadcasts", got, 6);
    res_grant = 0;
    chk("R2 all free", iss_ld_tag, 1);
  endtask

  task automatic t_done_order();
    mem_req_ready = 1; res_grant = 0;
    iss_ld_valid = 1; iss_ld_addr = 16'h0A00;
    @(negedge clk); iss_ld_addr = 16'h0A10;
    @(negedge clk); iss_ld_valid = 0;
    repeat (4) @(negedge clk);
    chk("R6 lowest first", res_tag, 1);
    chk("R6 data1", res_data, mdat(16'h0A00));
    res_grant = 1;
    @(negedge clk); res_grant = 0;
    chk("R6 second", res_tag, 2);
    chk("R6 data2", res_data, mdat(16'h0A10));
    res_grant = 1;
    @(negedge clk); res_grant = 0;
    chk("R6 empty", res_req, 0);
  endtask

  task automatic t_store_ready();
    int base;
    base = wr_count; mem_req_ready = 0;
    iss_st_valid = 1; iss_st_addr = 16'h0200; iss_st_data = 32'h0000CAFE; iss_st_src = 0;
    @(negedge clk); iss_st_valid = 0;
    chk("R7 wr valid", mem_req_valid, 1);
    chk("R7 wr we", mem_req_we, 1);
    chk("R7 wr addr", mem_req_addr, 16'h0200);
    chk("R7 wr data", mem_req_wdata, 32'h0000CAFE);
    mem_req_ready = 1;
    @(negedge clk);
    chk("R7 freed", mem_req_valid, 0);
    chk("R7 one write", wr_count - base, 1);
    chk("R7 logged", wr_data[base], 32'h0000CAFE);
  endtask

  task automatic t_store_snoop();
    int base;
    base = wr_count; mem_req_ready = 1;
    iss_st_valid = 1; iss_st_addr = 16'h0300; iss_st_data = 32'hDEADDEAD; iss_st_src = 5;
    @(negedge clk); iss_st_valid = 0;
    chk("R7 waits", mem_req_valid, 0);
    snp_valid = 1; snp_tag = 4; snp_data = 32'h11110000;
    @(negedge clk); snp_valid = 0;
    chk("R8 other tag ignored", mem_req_valid, 0);
    snp_valid = 1; snp_tag = 5; snp_data = 32'h12345678;
    @(negedge clk); snp_valid = 0;
    chk("R8 captured", mem_req_valid, 1);
    chk("R8 data", mem_req_wdata, 32'h12345678);
    @(negedge clk);
    chk("R8 logged", wr_data[base], 32'h12345678);
    iss_st_valid = 1; iss_st_addr = 16'h0310; iss_st_src = 3;
    snp_valid = 1; snp_tag = 3; snp_data = 32'h0BADF00D;
    @(negedge clk); iss_st_valid = 0; snp_valid = 0;
    chk("R8 issue-cycle capture", mem_req_valid, 1);
    chk("R8 issue-cycle data", mem_req_wdata, 32'h0BADF00D);
    @(negedge clk);
    chk("R8 writes", wr_count - base, 2);
  endtask

  task automatic t_store_full();
    int base;
    base = wr_count; mem_req_ready = 0;
    for (int i = 0; i < 3; i++) begin
      iss_st_valid = 1; iss_st_addr = 16'h0400 + 16'(4 * i); iss_st_src = 7;
      @(negedge clk);
    end
    iss_st_valid = 0;
    chk("R3 full", iss_st_ready, 0);
    chk("R7 none ready", mem_req_valid, 0);
    snp_valid = 1; snp_tag = 7; snp_data = 32'h77777777;
    @(negedge clk); snp_valid = 0; mem_req_ready = 1;
    for (int i = 0; i < 3; i++) begin
      chk("R9 store order", mem_req_addr, 16'h0400 + 16'(4 * i));
      chk("R8 all captured", mem_req_wdata, 32'h77777777);
      @(negedge clk);
    end
    chk("R3 freed", iss_st_ready, 1);
    chk("R7 three writes", wr_count - base, 3);
  endtask

  task automatic t_priority();
    int base;
    base = wr_count; mem_req_ready = 0; res_grant = 0;
    iss_st_valid = 1; iss_st_addr = 16'h0500; iss_st_data = 32'h55555555; iss_st_src = 0;
    @(negedge clk); iss_st_valid = 0;
    chk("R9 store alone", mem_req_we, 1);
    iss_ld_valid = 1; iss_ld_addr = 16'h0600;
    @(negedge clk); iss_ld_valid = 0;
    chk("R9 load wins we", mem_req_we, 0);
    chk("R9 load wins addr", mem_req_addr, 16'h0600);
    mem_req_ready = 1;
    @(negedge clk);
    chk("R9 store next", mem_req_we, 1);
    chk("R9 store addr", mem_req_addr, 16'h0500);
    @(negedge clk);
    chk("R9 written", wr_addr[base], 16'h0500);
    chk("R5 load offer", res_tag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single_load();   drain();
    t_fill_loads();    drain();
    t_done_order();    drain();
    t_store_ready();   drain();
    t_store_snoop();   drain();
    t_store_full();    drain();
    t_priority();      drain();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule